// File: doc/BRIEF.md
# Oscillator Power Sequencer

This block orders the events that take a divided clock source down to a powered-off state and bring it back up. It runs on the free-running master clock. A qualifier pulse marks each rising edge of the prescaled clock (MCLK), and the stabilisation wait counts only those pulses. The block drives the enables for the oscillator and the MCLK gate, drive enables for the main and reference outputs, and a hold request for the output divider. It also supplies the prescale and divide values the dividers should use: forced to their maximum while the oscillator settles, and the programmed values afterwards.

Shutdown runs in a fixed order. The sequencer first holds the divider, then waits for the main output to be low before tri-stating it. It then stops MCLK and tri-states the reference output, and finally turns the oscillator off. Start-up reverses this. The oscillator and MCLK come on with the dividers forced to maximum. The sequencer waits for the synchronised enable input, then counts 256 MCLK periods and restores the programmed values. After a power-on reset it instead pulses a load strobe so that the values are fetched from nonvolatile storage. The reference output starts next, if it is configured, and the main output starts one cycle after that. A power-down request that arrives part-way through start-up turns the block straight round into shutdown.

Top module: `osc_pwr_seq`

## Requirements
- R1: `pdn_n` passes through a two-flop synchroniser. When it falls in the running state, `div_hold` rises at the third rising clock edge after the change, and `out1_oe` is still 1 at that point.
- R2: During shutdown from the running state, `out1_oe` stays 1 for as long as `main_low` is 0. It drops at the first clock edge that samples `main_low` as 1.
- R3: One edge after `out1_oe` drops, `mclk_en` and `out0_oe` both drop while `osc_en` stays 1. `osc_en` drops on the following edge. `mclk_en` is never 1 while `osc_en` is 0.
- R4: When a power-down request is released, `osc_en`, `mclk_en` and `force_max` are all 1 at the third edge. While `force_max` is 1, `m_eff` equals M_MAX (default 4), `n_eff` equals N_MAX (default 513), and both drive enables are 0.
- R5: The stabilisation count does not start while the synchronised `oe` is 0. The block stays in its pre-wait step with the outputs tri-stated for as long as `oe` is low.
- R6: The stabilisation wait lasts 256 cycles in which `mclk_tick` is 1. Cycles with `mclk_tick` at 0 do not count. One edge after the 256th counted cycle, `force_max` drops and `m_eff` and `n_eff` take `prog_m` and `prog_n`.
- R7: One edge after the values are restored, `out0_oe` takes `ref_en`. `out1_oe` rises one edge later. With `ref_en` at 0, `out0_oe` stays 0 while the main output runs.
- R8: `nv_load` is a one-cycle pulse that coincides with the restore step of the first start-up after a power-on reset. This includes a start-up that follows a power-down which interrupted the first one. A start-up after a plain power-down gives no pulse.
- R9: A power-down request seen before the main output has started drops `mclk_en` and `out0_oe` on the edge that sees it, without waiting for `main_low`. `osc_en` drops on the next edge.
- R10: In the running state, `div_hold` is the inverse of `oe` after the two-flop synchroniser, so it rises on the third edge after `oe` falls. In every other state `div_hold` is 1. `div_hold` is 1 whenever `out1_oe` is 0.
- R11: While `rst` is high: `osc_en`, `mclk_en`, `out0_oe`, `out1_oe` and `nv_load` are 0, and `div_hold` and `force_max` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| pdn_n | input | 1 | Power-down request, active low, asynchronous |
| oe | input | 1 | Output enable, asynchronous |
| mclk_tick | input | 1 | One-cycle pulse per prescaled clock edge |
| main_low | input | 1 | Main output is currently low |
| prog_m | input | M_W | Programmed prescale value |
| prog_n | input | N_W | Programmed divide value |
| ref_en | input | 1 | Reference output configured on |
| div_hold | output | 1 | Hold/reset request to the output divider |
| out1_oe | output | 1 | Drive enable of main output (0 = high impedance) |
| out0_oe | output | 1 | Drive enable of reference output (0 = high impedance) |
| mclk_en | output | 1 | Glitch-free MCLK gate enable |
| osc_en | output | 1 | Master oscillator enable |
| force_max | output | 1 | Divider values forced to maximum |
| m_eff | output | M_W | Prescale value for the dividers |
| n_eff | output | N_W | Divide value for the dividers |
| nv_load | output | 1 | Load strobe to the nonvolatile value store |

## Verification
A sequencer stuck in the wrong step shows at the drive and gate enables within a cycle. An early exit from the pre-wait or stabilisation step makes the reference output rise before its exact edge count after reset or release. A skipped or reordered shutdown step makes the main drive enable fall before `main_low` is seen, or makes MCLK stop in the same cycle as the main output is tri-stated. A lost power-on flag shows on the next start-up as a missing or extra load strobe in the restore cycle. A stabilisation counter that ignores its qualifier shows as a start-up that finishes while `mclk_tick` is held low.

// File: rtl/osc_pwr_seq_pkg.sv
package osc_pwr_seq_pkg;
  typedef enum logic [3:0] {
    ST_INIT,
    ST_OFF,
    ST_PRE_WAIT,
    ST_STAB,
    ST_RESTORE,
    ST_REF_ON,
    ST_RUN,
    ST_DN_HOLD,
    ST_DN_OUT1Z,
    ST_DN_MCLK
  } seq_state_t;
endpackage

// File: rtl/osc_pwr_seq_sync.sv
module osc_pwr_seq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/osc_pwr_seq_cnt.sv
module osc_pwr_seq_cnt #(
  parameter int CW = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic done
);
  localparam logic [CW-1:0] LAST = {CW{1'b1}};
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  assign done = tick && (cnt == LAST);
endmodule

// File: rtl/osc_pwr_seq_fsm.sv
module osc_pwr_seq_fsm
  import osc_pwr_seq_pkg::*;
#(
  parameter int M_W   = 3,
  parameter int N_W   = 10,
  parameter int M_MAX = 4,
  parameter int N_MAX = 513
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pd_req,
  input  logic           oe_s,
  input  logic           stab_done,
  input  logic           main_low,
  input  logic           ref_en,
  input  logic [M_W-1:0] prog_m,
  input  logic [N_W-1:0] prog_n,
  output logic           stab_run,
  output logic           div_hold,
  output logic           out1_oe,
  output logic           out0_oe,
  output logic           mclk_en,
  output logic           osc_en,
  output logic           force_max,
  output logic [M_W-1:0] m_eff,
  output logic [N_W-1:0] n_eff,
  output logic           nv_load
);
  localparam logic [M_W-1:0] M_TOP = M_W'(M_MAX);
  localparam logic [N_W-1:0] N_TOP = N_W'(N_MAX);

  seq_state_t st, nx;
  logic       from_por;
  logic       f_nx;

  // next-step selection
  always_comb begin
    nx = st;
    unique case (st)
      ST_INIT:     nx = pd_req ? ST_OFF : ST_PRE_WAIT;
      ST_OFF:      if (!pd_req) nx = ST_PRE_WAIT;
      ST_PRE_WAIT: if (pd_req) nx = ST_DN_MCLK; else if (oe_s) nx = ST_STAB;
      ST_STAB:     if (pd_req) nx = ST_DN_MCLK; else if (stab_done) nx = ST_RESTORE;
      ST_RESTORE:  nx = pd_req ? ST_DN_MCLK : ST_REF_ON;
      ST_REF_ON:   nx = pd_req ? ST_DN_MCLK : ST_RUN;
      ST_RUN:      if (pd_req) nx = ST_DN_HOLD;
      ST_DN_HOLD:  if (main_low) nx = ST_DN_OUT1Z;
      ST_DN_OUT1Z: nx = ST_DN_MCLK;
      ST_DN_MCLK:  nx = ST_OFF;
      default:     nx = ST_INIT;
    endcase
  end

  assign stab_run = (st == ST_STAB);
  assign f_nx = (nx == ST_INIT) || (nx == ST_OFF) ||
                (nx == ST_PRE_WAIT) || (nx == ST_STAB);

  // outputs registered from the next step so they move with the state
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_INIT;
      from_por  <= 1'b1;
      div_hold  <= 1'b1;
      out1_oe   <= 1'b0;
      out0_oe   <= 1'b0;
      mclk_en   <= 1'b0;
      osc_en    <= 1'b0;
      force_max <= 1'b1;
      m_eff     <= M_TOP;
      n_eff     <= N_TOP;
      nv_load   <= 1'b0;
    end else begin
      st        <= nx;
      if (st == ST_RESTORE) from_por <= 1'b0;
      div_hold  <= !((nx == ST_RUN) && oe_s);
      out1_oe   <= (nx == ST_RUN) || (nx == ST_DN_HOLD);
      out0_oe   <= ref_en && ((nx == ST_REF_ON) || (nx == ST_RUN) ||
                              (nx == ST_DN_HOLD) || (nx == ST_DN_OUT1Z));
      mclk_en   <= !((nx == ST_INIT) || (nx == ST_OFF) || (nx == ST_DN_MCLK));
      osc_en    <= !((nx == ST_INIT) || (nx == ST_OFF));
      force_max <= f_nx;
      m_eff     <= f_nx ? M_TOP : prog_m;
      n_eff     <= f_nx ? N_TOP : prog_n;
      nv_load   <= (nx == ST_RESTORE) && (st != ST_RESTORE) && from_por;
    end
  end
endmodule

// File: rtl/osc_pwr_seq.sv
module osc_pwr_seq #(
  parameter int M_W         = 3,
  parameter int N_W         = 10,
  parameter int M_MAX       = 4,
  parameter int N_MAX       = 513,
  parameter int STAB_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pdn_n,
  input  logic           oe,
  input  logic           mclk_tick,
  input  logic           main_low,
  input  logic [M_W-1:0] prog_m,
  input  logic [N_W-1:0] prog_n,
  input  logic           ref_en,
  output logic           div_hold,
  output logic           out1_oe,
  output logic           out0_oe,
  output logic           mclk_en,
  output logic           osc_en,
  output logic           force_max,
  output logic [M_W-1:0] m_eff,
  output logic [N_W-1:0] n_eff,
  output logic           nv_load
);
  logic pdn_s, oe_s, stab_run, stab_done;

  osc_pwr_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pdn_sync (
    .clk(clk), .rst(rst), .d(pdn_n), .q(pdn_s)
  );

  osc_pwr_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_oe_sync (
    .clk(clk), .rst(rst), .d(oe), .q(oe_s)
  );

  osc_pwr_seq_cnt #(.CW(STAB_W)) u_stab (
    .clk(clk), .rst(rst), .clr(!stab_run), .tick(mclk_tick), .done(stab_done)
  );

  osc_pwr_seq_fsm #(.M_W(M_W), .N_W(N_W), .M_MAX(M_MAX), .N_MAX(N_MAX)) u_fsm (
    .clk(clk), .rst(rst), .pd_req(!pdn_s), .oe_s(oe_s), .stab_done(stab_done),
    .main_low(main_low), .ref_en(ref_en), .prog_m(prog_m), .prog_n(prog_n),
    .stab_run(stab_run), .div_hold(div_hold), .out1_oe(out1_oe),
    .out0_oe(out0_oe), .mclk_en(mclk_en), .osc_en(osc_en),
    .force_max(force_max), .m_eff(m_eff), .n_eff(n_eff), .nv_load(nv_load)
  );
endmodule

// File: rtl/osc_pwr_seq_chk.sv
module osc_pwr_seq_chk (
  input logic clk,
  input logic rst,
  input logic main_low,
  input logic div_hold,
  input logic out1_oe,
  input logic out0_oe,
  input logic mclk_en,
  input logic osc_en,
  input logic force_max,
  input logic nv_load
);
  p_main_z_needs_low_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(out1_oe) |-> $past(main_low));

  p_mclk_off_after_main_z_r3: assert property (@(posedge clk) disable iff (rst)
    !mclk_en |-> !out1_oe);

  p_osc_covers_mclk_r3: assert property (@(posedge clk) disable iff (rst)
    mclk_en |-> osc_en);

  p_forced_outputs_z_r4: assert property (@(posedge clk) disable iff (rst)
    force_max |-> (!out0_oe && !out1_oe));

  p_restore_before_main_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(out1_oe) |-> $past(!force_max));

  p_load_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    nv_load |=> !nv_load);

  p_hold_when_main_z_r10: assert property (@(posedge clk) disable iff (rst)
    !out1_oe |-> div_hold);
endmodule

bind osc_pwr_seq osc_pwr_seq_chk u_chk (
  .clk(clk), .rst(rst), .main_low(main_low), .div_hold(div_hold),
  .out1_oe(out1_oe), .out0_oe(out0_oe), .mclk_en(mclk_en), .osc_en(osc_en),
  .force_max(force_max), .nv_load(nv_load)
);

// File: tb/test_osc_pwr_seq.sv
module test_osc_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int M_W = 3;
  localparam int N_W = 10;
  localparam int M_MAX = 4;
  localparam int N_MAX = 513;

  typedef struct packed {
    logic        pdn_n;
    logic        oe;
    logic        main_low;
    logic [15:0] wait_n;
    logic [5:0]  exp; // osc, mclk, out0, out1, hold, force
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b1, 1'b1, 1'b0, 16'd5,   6'b110011},  // R5 R4 counting
    '{1'b1, 1'b1, 1'b0, 16'd300, 6'b111100},  // R7 running
    '{1'b1, 1'b0, 1'b0, 16'd5,   6'b111110},  // R10 oe low
    '{1'b0, 1'b1, 1'b0, 16'd6,   6'b111110},  // R2 wait for low
    '{1'b0, 1'b1, 1'b1, 16'd6,   6'b000011},  // R3 off
    '{1'b1, 1'b0, 1'b0, 16'd20,  6'b110011},  // R5 held off
    '{1'b1, 1'b1, 1'b0, 16'd100, 6'b110011},  // R6 counting
    '{1'b1, 1'b1, 1'b0, 16'd200, 6'b111100}   // R7 running
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pdn_n = 1'b1, oe = 1'b1, mclk_tick = 1'b1, main_low = 1'b0, ref_en = 1'b1;
  logic [M_W-1:0] prog_m = 3'd2;
  logic [N_W-1:0] prog_n = 10'd7;
  logic div_hold, out1_oe, out0_oe, mclk_en, osc_en, force_max, nv_load;
  logic [M_W-1:0] m_eff;
  logic [N_W-1:0] n_eff;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_pwr_seq i_osc_pwr_seq (
    .clk(clk), .rst(rst), .pdn_n(pdn_n), .oe(oe), .mclk_tick(mclk_tick),
    .main_low(main_low), .prog_m(prog_m), .prog_n(prog_n), .ref_en(ref_en),
    .div_hold(div_hold), .out1_oe(out1_oe), .out0_oe(out0_oe),
    .mclk_en(mclk_en), .osc_en(osc_en), .force_max(force_max),
    .m_eff(m_eff), .n_eff(n_eff), .nv_load(nv_load)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  task automatic run_until_ref(input int limit, output int k, output bit saw);
    k = 0;
    saw = 1'b0;
    while (k < limit) begin
      @(negedge clk);
      k++;
      if (nv_load) saw = 1'b1;
      if (out0_oe) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    bit saw;

    // R11 reset state
    step(3);
    chk("R11", "osc_en", osc_en, 0);
    chk("R11", "mclk_en", mclk_en, 0);
    chk("R11", "out0_oe", out0_oe, 0);
    chk("R11", "out1_oe", out1_oe, 0);
    chk("R11", "div_hold", div_hold, 1);
    chk("R11", "force_max", force_max, 1);
    chk("R11", "nv_load", nv_load, 0);
    rst = 1'b0;

    // vector table
    for (int i = 0; i < 8; i++) begin
      pdn_n = TBL[i].pdn_n;
      oe = TBL[i].oe;
      main_low = TBL[i].main_low;
      step(int'(TBL[i].wait_n));
      chk("R4", "outputs", int'({osc_en, mclk_en, out0_oe, out1_oe, div_hold, force_max}),
          int'(TBL[i].exp));
      chk("R6", "m_eff", int'(m_eff), TBL[i].exp[0] ? M_MAX : int'(prog_m));
      chk("R6", "n_eff", int'(n_eff), TBL[i].exp[0] ? N_MAX : int'(prog_n));
    end

    // R1 R2 R3 precise shutdown from running
    pdn_n = 1'b0;
    step(2);
    chk("R1", "hold after 2 edges", div_hold, 0);
    step(1);
    chk("R1", "hold after 3 edges", div_hold, 1);
    chk("R1", "main still driven", out1_oe, 1);
    step(20);
    chk("R2", "main driven while high", out1_oe, 1);
    main_low = 1'b1;
    step(1);
    chk("R2", "main z after low", out1_oe, 0);
    chk("R3", "mclk still on", mclk_en, 1);
    step(1);
    chk("R3", "mclk off", mclk_en, 0);
    chk("R3", "ref z", out0_oe, 0);
    chk("R3", "osc still on", osc_en, 1);
    step(1);
    chk("R3", "osc off", osc_en, 0);
    main_low = 1'b0;

    // R4 R8 plain start-up
    pdn_n = 1'b1;
    step(3);
    chk("R4", "osc on at edge 3", osc_en, 1);
    chk("R4", "mclk on at edge 3", mclk_en, 1);
    chk("R4", "force at edge 3", force_max, 1);
    chk("R4", "m max", int'(m_eff), M_MAX);
    run_until_ref(2000, k, saw);
    chk("R6", "edges to ref after release", k + 3, 261);
    chk("R8", "no load after plain power-down", saw, 0);
    chk("R7", "main waits one edge", out1_oe, 0);
    step(1);
    chk("R7", "main on", out1_oe, 1);
    chk("R6", "m restored", int'(m_eff), int'(prog_m));

    // R9 power-down during the stabilisation wait
    pdn_n = 1'b0;
    main_low = 1'b1;
    step(10);
    main_low = 1'b0;
    pdn_n = 1'b1;
    step(50);
    pdn_n = 1'b0;
    step(2);
    chk("R9", "mclk before seen", mclk_en, 1);
    step(1);
    chk("R9", "mclk off no low wait", mclk_en, 0);
    chk("R9", "osc on", osc_en, 1);
    step(1);
    chk("R9", "osc off", osc_en, 0);

    // R6 R8 power-on start-up timing
    pdn_n = 1'b1;
    do_reset();
    run_until_ref(2000, k, saw);
    chk("R6", "edges to ref after reset", k, 260);
    chk("R8", "load after reset", saw, 1);
    step(1);
    chk("R7", "main on after reset", out1_oe, 1);

    // R8 reset, then power-down before restore
    pdn_n = 1'b0;
    do_reset();
    step(10);
    chk("R8", "off before restore", osc_en, 0);
    pdn_n = 1'b1;
    run_until_ref(2000, k, saw);
    chk("R8", "load kept for first start-up", saw, 1);
    chk("R8", "edges to ref", k, 261);

    // R6 qualifier held low
    mclk_tick = 1'b0;
    do_reset();
    step(300);
    chk("R6", "no tick keeps force", force_max, 1);
    chk("R6", "no tick keeps ref z", out0_oe, 0);
    mclk_tick = 1'b1;
    run_until_ref(2000, k, saw);
    chk("R6", "edges to ref after tick on", k, 257);

    // R7 reference output not configured
    ref_en = 1'b0;
    do_reset();
    step(300);
    chk("R7", "main on without ref", out1_oe, 1);
    chk("R7", "ref stays z", out0_oe, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule